// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block watches the receive side of a 10 Mb/s twisted-pair port and decides whether the cable is alive. Upstream logic delivers two single-cycle strobes: one for a detected link pulse and one for the start of a received packet. A free-running divider turns the core clock into a millisecond tick. Every timer in the block counts whole milliseconds of that tick.

Two timers drive the decision. The loss timer starts again on every accepted pulse and on every data strobe. If it runs out, the monitor declares link fail and asserts an inhibit that blocks the transmit path and the normal loopback path. The gap timer rejects any pulse that follows the last accepted pulse too soon. Link fail ends on a received packet, or once enough accepted pulses have been counted. If the loss interval expires while the monitor is collecting these pulses, the count starts again from zero. A low enable switches link testing off, and the link is then reported as good.

Top module: `link_integrity_mon`

## Requirements
- R1: While `linkTestEn` is low, `linkFail` and `txInhibit` are 0, the state is held good and the loss timer is held cleared. After `linkTestEn` returns high, link fail cannot occur until the full loss interval has passed.
- R2: With `linkTestEn` high and the link good, link fail is entered once LOSS_MS millisecond ticks pass with no accepted pulse and no data strobe. `linkFail` rises in the cycle after the expired timer is sampled.
- R3: `txInhibit` always equals `linkFail`.
- R4: A pulse strobe is accepted only once at least MIN_GAP_MS ticks have passed since the last accepted pulse. A rejected pulse does not restart the loss timer, does not count toward recovery and does not restart the gap timer.
- R5: In link fail, a data strobe with `linkTestEn` high returns the link to good in the next cycle.
- R6: In link fail, accepted pulses are counted, and the RECOVER_PULSES-th accepted pulse returns the link to good in the next cycle. With the default of 2, a single accepted pulse leaves the link in fail.
- R7: The loss timer restarts on every accepted pulse and on every data strobe, whatever the state.
- R8: In link fail, if the loss interval expires before recovery, the accepted-pulse count is cleared and the loss timer restarts.
- R9: After reset the monitor is in link fail with every counter at zero. The gap timer is therefore closed, and the first pulse is accepted only after MIN_GAP_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkTestEn | input | 1 | Link testing enabled when high |
| pulseIn | input | 1 | Single-cycle link pulse strobe |
| dataIn | input | 1 | Single-cycle start-of-packet strobe |
| linkFail | output | 1 | High while the link is declared failed |
| txInhibit | output | 1 | Blocks transmit and normal loopback; equals linkFail |

## Verification
On every cycle, the embedded assertions check the following:
- accepted pulses only arrive with the gap timer open;
- the recovery count stays below its limit;
- a disabled monitor is held good;
- an expired loss timer in the good state, with no activity present, leads to fail;
- a data strobe always ends fail;
- a pulse that does not complete the count leaves the link in fail.

Some behaviour depends on the millisecond tick phase and on the history of strobes. This includes rejected pulses leaving both timers untouched, the grace interval after re-enable, and the count being cleared on expiry during recovery. Only the bench scenarios can show these, so the bench compares the outputs on every cycle with its own cycle-level model.

// File: rtl/lim_pkg.sv
package lim_pkg;
  // Commands from control to the timer and counter datapath
  typedef struct packed {
    logic restartLoss;
    logic restartGap;
    logic countPulse;
    logic clearPulses;
  } limStrobes_t;
endpackage

// File: rtl/lim_datapath.sv
module lim_datapath
  import lim_pkg::*;
#(
  parameter int TICK_DIV       = 10000,
  parameter int LOSS_MS        = 100,
  parameter int MIN_GAP_MS     = 4,
  parameter int RECOVER_PULSES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  limStrobes_t strobes,
  output logic        lossExpired,
  output logic        gapOpen,
  output logic        lastPulse
);
  localparam int LOSS_W = $clog2(LOSS_MS + 1);
  localparam int GAP_W  = $clog2(MIN_GAP_MS + 1);
  localparam int CNT_W  = $clog2(RECOVER_PULSES + 1);
  localparam int DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic              msTick;
  logic [LOSS_W-1:0] lossCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [CNT_W-1:0]  pulseCnt;

  generate
    if (TICK_DIV == 1) begin : g_noDiv
      assign msTick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign msTick = (divCnt == DIV_W'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lossCnt <= '0;
    else if (strobes.restartLoss) lossCnt <= '0;
    else if (msTick && lossCnt != LOSS_W'(LOSS_MS)) lossCnt <= lossCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= '0;
    else if (strobes.restartGap) gapCnt <= '0;
    else if (msTick && gapCnt != GAP_W'(MIN_GAP_MS)) gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (strobes.clearPulses) pulseCnt <= '0;
    else if (strobes.countPulse) pulseCnt <= pulseCnt + 1'b1;
  end

  assign lossExpired = (lossCnt == LOSS_W'(LOSS_MS));
  assign gapOpen     = (gapCnt == GAP_W'(MIN_GAP_MS));
  assign lastPulse   = (pulseCnt == CNT_W'(RECOVER_PULSES - 1));

  // R4: control may accept a pulse only after the minimum gap
  a_r4_accept_needs_gap: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restartGap |-> gapCnt == GAP_W'(MIN_GAP_MS));
  // R6/R8: the recovery count never reaches its limit, it recovers or clears
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt < CNT_W'(RECOVER_PULSES));
endmodule

// File: rtl/lim_control.sv
module lim_control
  import lim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkTestEn,
  input  logic        pulseIn,
  input  logic        dataIn,
  input  logic        lossExpired,
  input  logic        gapOpen,
  input  logic        lastPulse,
  output limStrobes_t strobes,
  output logic        stateFail
);
  typedef enum logic {LINK_GOOD = 1'b0, LINK_FAIL = 1'b1} linkState_t;
  linkState_t state, stateNext;
  logic accepted;

  assign accepted = linkTestEn && pulseIn && gapOpen;

  always_comb begin
    strobes            = '0;
    strobes.restartGap = accepted;
    stateNext          = state;
    if (!linkTestEn) begin
      stateNext           = LINK_GOOD;
      strobes.restartLoss = 1'b1;
      strobes.clearPulses = 1'b1;
    end else if (state == LINK_GOOD) begin
      if (dataIn || accepted) begin
        strobes.restartLoss = 1'b1;
      end else if (lossExpired) begin
        stateNext           = LINK_FAIL;
        strobes.restartLoss = 1'b1;
        strobes.clearPulses = 1'b1;
      end
    end else begin
      if (dataIn) begin
        stateNext           = LINK_GOOD;
        strobes.restartLoss = 1'b1;
        strobes.clearPulses = 1'b1;
      end else if (accepted) begin
        strobes.restartLoss = 1'b1;
        if (lastPulse) begin
          stateNext           = LINK_GOOD;
          strobes.clearPulses = 1'b1;
        end else begin
          strobes.countPulse = 1'b1;
        end
      end else if (lossExpired) begin
        strobes.restartLoss = 1'b1;
        strobes.clearPulses = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LINK_FAIL;
    else state <= stateNext;
  end

  assign stateFail = (state == LINK_FAIL);

  a_r1_disabled_held_good: assert property (@(posedge clk) disable iff (!rstN)
    !linkTestEn |=> !stateFail);
  a_r2_timeout_enters_fail: assert property (@(posedge clk) disable iff (!rstN)
    (linkTestEn && !stateFail && lossExpired && !dataIn && !pulseIn) |=> stateFail);
  a_r5_data_recovers: assert property (@(posedge clk) disable iff (!rstN)
    (linkTestEn && stateFail && dataIn) |=> !stateFail);
  a_r6_partial_count_stays_fail: assert property (@(posedge clk) disable iff (!rstN)
    (stateFail && strobes.countPulse) |=> stateFail);
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
  import lim_pkg::*;
#(
  parameter int TICK_DIV       = 10000,
  parameter int LOSS_MS        = 100,
  parameter int MIN_GAP_MS     = 4,
  parameter int RECOVER_PULSES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkTestEn,
  input  logic pulseIn,
  input  logic dataIn,
  output logic linkFail,
  output logic txInhibit
);
  limStrobes_t strobes;
  logic lossExpired, gapOpen, lastPulse, stateFail;

  lim_control u_control (
    .clk(clk), .rstN(rstN), .linkTestEn(linkTestEn), .pulseIn(pulseIn),
    .dataIn(dataIn), .lossExpired(lossExpired), .gapOpen(gapOpen),
    .lastPulse(lastPulse), .strobes(strobes), .stateFail(stateFail)
  );

  lim_datapath #(
    .TICK_DIV(TICK_DIV), .LOSS_MS(LOSS_MS),
    .MIN_GAP_MS(MIN_GAP_MS), .RECOVER_PULSES(RECOVER_PULSES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lossExpired(lossExpired),
    .gapOpen(gapOpen), .lastPulse(lastPulse)
  );

  // R1: the failed state is reported only while link testing is enabled
  assign linkFail  = linkTestEn && stateFail;
  // R3: the inhibit for transmit and loopback follows the failure flag
  assign txInhibit = linkFail;
endmodule

// File: tb/link_integrity_mon_tb.sv
`timescale 1ns/1ps
module link_integrity_mon_tb;
  localparam int DIV  = 4;
  localparam int LOSS = 20;
  localparam int GAP  = 3;
  localparam int REC  = 2;
  localparam int MS   = DIV;

  logic clk = 1'b0, rstN = 1'b0, en = 1'b1, pulse = 1'b0, dat = 1'b0;
  logic linkFail, txInhibit;
  int total = 0, bad = 0;
  string phase = "R9 reset";
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_integrity_mon #(.TICK_DIV(DIV), .LOSS_MS(LOSS), .MIN_GAP_MS(GAP),
    .RECOVER_PULSES(REC)) u_dut (
    .clk(clk), .rstN(rstN), .linkTestEn(en), .pulseIn(pulse), .dataIn(dat),
    .linkFail(linkFail), .txInhibit(txInhibit));

  // Reference model built from the requirements
  int mDiv, mLoss, mGap, mCnt;
  bit mFail;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDiv = 0; mLoss = 0; mGap = 0; mCnt = 0; mFail = 1;
    end else begin
      bit tick, acc, rl, cp, cl, nf;
      tick = (mDiv == DIV - 1);
      acc = en && pulse && (mGap == GAP);
      rl = 0; cp = 0; cl = 0; nf = mFail;
      if (!en) begin nf = 0; rl = 1; cl = 1; end
      else if (!mFail) begin
        if (dat || acc) rl = 1;
        else if (mLoss == LOSS) begin nf = 1; rl = 1; cl = 1; end
      end else begin
        if (dat) begin nf = 0; rl = 1; cl = 1; end
        else if (acc) begin
          rl = 1;
          if (mCnt == REC - 1) begin nf = 0; cl = 1; end else cp = 1;
        end else if (mLoss == LOSS) begin rl = 1; cl = 1; end
      end
      mDiv  = tick ? 0 : mDiv + 1;
      mLoss = rl ? 0 : ((tick && mLoss < LOSS) ? mLoss + 1 : mLoss);
      mGap  = acc ? 0 : ((tick && mGap < GAP) ? mGap + 1 : mGap);
      mCnt  = cl ? 0 : (cp ? mCnt + 1 : mCnt);
      mFail = nf;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, tagged with the active scenario
  always @(negedge clk) if (rstN && !done) begin
    chk(phase, linkFail, mFail && en);
    chk("R3 inhibit", txInhibit, linkFail);
  end

  task automatic drive(logic p, logic d);
    @(posedge clk); #1; pulse = p; dat = d;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0);
  endtask
  task automatic sendPulse(); drive(1, 0); drive(0, 0); endtask
  task automatic sendData();  drive(0, 1); drive(0, 0); endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #22 rstN = 1'b1;
    #1 chk("R9 reset fail", linkFail, 1'b1);
    chk("R9 reset inhibit", txInhibit, 1'b1);
    phase = "R9 early pulse rejected";
    sendPulse(); sendPulse();
    chk("R9 early pulses ignored", linkFail, 1'b1);
    idle(GAP * MS + 2);
    phase = "R6 pulse recovery";
    sendPulse();
    chk("R6 one pulse insufficient", linkFail, 1'b1);
    phase = "R4 close pulse rejected";
    idle(2); sendPulse();
    chk("R4 close pulse not counted", linkFail, 1'b1);
    idle(GAP * MS + 2);
    phase = "R6 pulse recovery";
    sendPulse();
    chk("R6 second pulse recovers", linkFail, 1'b0);
    phase = "R2 loss timeout";
    idle(LOSS * MS - 2 * MS);
    chk("R2 no fail before interval", linkFail, 1'b0);
    idle(3 * MS);
    chk("R2 fail after interval", linkFail, 1'b1);
    phase = "R5 data recovery";
    sendData();
    chk("R5 data recovers", linkFail, 1'b0);
    phase = "R7 keep alive";
    for (int i = 0; i < 12; i++) begin
      idle((LOSS - 6) * MS);
      if (i % 3 == 0) sendData(); else sendPulse();
    end
    chk("R7 activity keeps link good", linkFail, 1'b0);
    phase = "R4 rejected pulses do not refresh";
    for (int i = 0; i < LOSS * MS + 3 * MS; i++) drive(i % 2 == 0 && i < 3, 0);
    chk("R4 lone burst lets link fail", linkFail, 1'b1);
    phase = "R8 count cleared on expiry";
    idle(GAP * MS + 2); sendPulse();
    idle(LOSS * MS + 2 * MS); sendPulse();
    chk("R8 stale count cleared", linkFail, 1'b1);
    idle(GAP * MS + 2); sendPulse();
    chk("R8 fresh pair recovers", linkFail, 1'b0);
    phase = "R1 disabled";
    idle(LOSS * MS + 2 * MS);
    en = 1'b0; #1;
    chk("R1 disabled reports good", linkFail, 1'b0);
    idle(LOSS * MS * 2);
    chk("R1 still good while disabled", linkFail, 1'b0);
    en = 1'b1;
    idle(LOSS * MS - 2 * MS);
    chk("R1 grace after re-enable", linkFail, 1'b0);
    idle(4 * MS);
    chk("R2 fail after re-enable interval", linkFail, 1'b1);
    phase = "R2 R4 R5 R6 R8 random";
    for (int i = 0; i < 30000; i++) begin
      if (i % 5000 == 4000) en = 1'b0;
      if (i % 5000 == 4300) en = 1'b1;
      drive(($urandom % 45) == 0, ($urandom % 700) == 0);
    end
    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule